// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on a small I/O bus and implements the two-port indirect scheme used to reach device configuration registers. One port holds a 32-bit configuration address. A four-byte data window reads and writes the configuration register that the address selects. The configuration address carries an enable bit, a bus number, a device number, a function number and a register offset. The block stores that address with its reserved bits forced to zero. Accesses through the data window become single-cycle requests on a configuration-space side port, which supplies the offset, the size and the write data, and returns read data with a valid strobe.

Only one bus/device/function is served: the target set on the `tgt_*` inputs. Data-window accesses aimed anywhere else go nowhere. Such a read returns zero and such a write is dropped. Every request the block does not recognise completes one cycle later with zero read data. This covers wrong sizes, wrong ports, and the data window while the enable bit is clear.

Top module: `cfg_mech_decoder`

## Requirements
- R1: After reset the configuration address is 0, so the enable bit is clear, and neither `io_done` nor `cs_req` is asserted until a request arrives.
- R2: A dword (size code 2) write to the address port stores the write data ANDed with 0x80FFFFFC. A dword read of the address port returns the stored value. Both complete with `io_done` one cycle after the request.
- R3: No access through the data window reaches the side port while bit 31 of the configuration address is clear.
- R4: Byte (size code 0) and word (size code 1) accesses are accepted at every port from DATA_PORT to DATA_PORT+3. The forwarded offset is address bits 7:0 plus (port − DATA_PORT).
- R5: Dword accesses are forwarded only at DATA_PORT, with offset equal to address bits 7:0.
- R6: The function number is address bits 10:8, the device number bits 15:11 and the bus number bits 23:16. If any of them differs from the target, the access is not forwarded, a read returns 0, and a write leaves configuration space unchanged.
- R7: Unrecognised requests complete one cycle later with read data 0 and no side-port request. These include byte and word accesses to the address port (which leave the address unchanged), dword accesses at DATA_PORT+1 to DATA_PORT+3, and any other port.
- R8: A forwarded access raises `cs_req` for exactly one cycle, one cycle after the bus request. A forwarded write signals `io_done` in that same cycle.
- R9: A forwarded read completes with `io_done` one cycle after the first `cs_rvalid` seen while the read is pending. This includes a response in the same cycle as `cs_req`. `cs_rvalid` at any other time has no effect.
- R10: Forwarded read data is zero-extended to the access size: a byte read returns response bits 7:0 only, and a word read returns bits 15:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle bus request strobe |
| io_port | input | PORT_W | I/O port number |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wr | input | 1 | 1 write, 0 read |
| io_wdata | input | 32 | Write data, low-aligned |
| io_done | output | 1 | One-cycle completion strobe |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_busy | output | 1 | A forwarded read is waiting for its response |
| tgt_bus | input | 8 | Served bus number |
| tgt_dev | input | 5 | Served device number |
| tgt_fn | input | 3 | Served function number |
| cs_req | output | 1 | Side-port request pulse |
| cs_wr | output | 1 | Side-port write flag |
| cs_off | output | 8 | Configuration register byte offset |
| cs_size | output | 2 | Side-port access size |
| cs_wdata | output | 32 | Side-port write data |
| cs_rvalid | input | 1 | Side-port read response valid |
| cs_rdata | input | 32 | Side-port read response data |

## Verification
Two events can fall in one cycle: issuing a side-port request and capturing its response. The bench provokes this by returning `cs_rvalid` in the very cycle `cs_req` is high, and also runs the same read with a three-cycle delay. In both cases `io_done` must rise exactly one cycle after the response, with the size-masked word. A stray `cs_rvalid` is also pulsed while nothing is pending, and the bench checks that no completion follows.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } cfg_size_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_ADDR_WR = 2'd1,
    ACT_ADDR_RD = 2'd2,
    ACT_FWD     = 2'd3
  } cfg_act_e;

  localparam logic [31:0] ADDR_KEEP = 32'h80FF_FFFC;

  function automatic logic [31:0] cfg_mask_addr(input logic [31:0] raw);
    return raw & ADDR_KEEP;
  endfunction

  function automatic logic cfg_enabled(input logic [31:0] a);
    return a[31];
  endfunction

  function automatic logic [7:0] cfg_bus(input logic [31:0] a);
    return a[23:16];
  endfunction

  function automatic logic [4:0] cfg_dev(input logic [31:0] a);
    return a[15:11];
  endfunction

  function automatic logic [2:0] cfg_fn(input logic [31:0] a);
    return a[10:8];
  endfunction

  function automatic logic [7:0] cfg_offset(input logic [7:0] base, input logic [1:0] lane);
    return base + {6'd0, lane};
  endfunction

  function automatic logic [31:0] cfg_size_mask(input cfg_size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_WORD: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgd_addr_reg.sv
module cfgd_addr_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] addr_q
);
  import cfgd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= 32'd0;
    else if (wr_en) addr_q <= cfg_mask_addr(wdata);
  end

  AST_ADDR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & ~ADDR_KEEP) == 32'd0);  // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));  // R7

endmodule

// File: rtl/cfgd_decode.sv
module cfgd_decode #(
  parameter int          PORT_W    = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic [PORT_W-1:0]   io_port,
  input  cfgd_pkg::cfg_size_e io_size,
  input  logic                cfg_en,
  input  logic [7:0]          cfg_bus_no,
  input  logic [4:0]          cfg_dev_no,
  input  logic [2:0]          cfg_fn_no,
  input  logic [7:0]          cfg_base_off,
  input  logic [7:0]          tgt_bus,
  input  logic [4:0]          tgt_dev,
  input  logic [2:0]          tgt_fn,
  input  logic                io_wr,
  output cfgd_pkg::cfg_act_e  act,
  output logic [7:0]          fwd_off
);
  import cfgd_pkg::*;

  localparam logic [PORT_W-1:0] A_PORT = PORT_W'(ADDR_PORT);
  localparam logic [PORT_W-1:0] D_PORT = PORT_W'(DATA_PORT);
  localparam logic [PORT_W-1:0] D_LAST = PORT_W'(DATA_PORT + 16'd3);

  logic              hit_addr;
  logic              in_window;
  logic              at_first;
  logic [PORT_W-1:0] rel;
  logic [1:0]        lane;
  logic              target_ok;
  logic              narrow;
  logic              window_ok;

  assign hit_addr  = (io_port == A_PORT);
  assign in_window = (io_port >= D_PORT) && (io_port <= D_LAST);
  assign at_first  = (io_port == D_PORT);
  assign rel       = io_port - D_PORT;
  assign lane      = rel[1:0];
  assign target_ok = (cfg_bus_no == tgt_bus) && (cfg_dev_no == tgt_dev) &&
                     (cfg_fn_no == tgt_fn);
  assign narrow    = (io_size == SZ_BYTE) || (io_size == SZ_WORD);
  assign window_ok = (narrow && in_window) || ((io_size == SZ_DWORD) && at_first);

  always_comb begin
    act     = ACT_NONE;
    fwd_off = 8'd0;
    if (hit_addr && io_size == SZ_DWORD) begin
      act = io_wr ? ACT_ADDR_WR : ACT_ADDR_RD;
    end else if (window_ok && cfg_en && target_ok) begin
      act     = ACT_FWD;
      fwd_off = (io_size == SZ_DWORD) ? cfg_base_off : cfg_offset(cfg_base_off, lane);
    end
  end

endmodule

// File: rtl/cfgd_fwd_ctrl.sv
module cfgd_fwd_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  cfgd_pkg::cfg_act_e  act,
  input  logic [7:0]          fwd_off,
  input  cfgd_pkg::cfg_size_e io_size,
  input  logic                io_wr,
  input  logic [31:0]         io_wdata,
  input  logic [31:0]         addr_q,
  output logic                io_done,
  output logic [31:0]         io_rdata,
  output logic                busy,
  output logic                cs_req,
  output logic                cs_wr,
  output logic [7:0]          cs_off,
  output cfgd_pkg::cfg_size_e cs_size,
  output logic [31:0]         cs_wdata,
  input  logic                cs_rvalid,
  input  logic [31:0]         cs_rdata
);
  import cfgd_pkg::*;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;
  st_e state;

  logic resp_take;
  logic resp_wait;
  assign resp_take = (state == ST_WAIT) && cs_rvalid;
  assign resp_wait = (state == ST_WAIT) && !cs_rvalid;
  assign busy      = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      io_done  <= 1'b0;
      io_rdata <= 32'd0;
      cs_req   <= 1'b0;
      cs_wr    <= 1'b0;
      cs_off   <= 8'd0;
      cs_size  <= SZ_BYTE;
      cs_wdata <= 32'd0;
    end else begin
      io_done <= 1'b0;
      cs_req  <= 1'b0;
      if (resp_take) begin
        io_done  <= 1'b1;
        io_rdata <= cs_rdata & cfg_size_mask(cs_size);
        state    <= ST_IDLE;
      end else if (start) begin
        case (act)
          ACT_FWD: begin
            cs_req   <= 1'b1;
            cs_wr    <= io_wr;
            cs_off   <= fwd_off;
            cs_size  <= io_size;
            cs_wdata <= io_wdata;
            io_rdata <= 32'd0;
            if (io_wr) io_done <= 1'b1;
            else       state   <= ST_WAIT;
          end
          ACT_ADDR_RD: begin
            io_done  <= 1'b1;
            io_rdata <= addr_q;
          end
          default: begin
            io_done  <= 1'b1;
            io_rdata <= 32'd0;
          end
        endcase
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |=> !cs_req);  // R8
  AST_WR_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && cs_wr) |-> io_done);  // R8
  AST_RD_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_wait |=> !io_done);  // R9
  AST_RD_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_take |=> (io_done && !busy));  // R9
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_take && cs_size == SZ_BYTE) |=> (io_rdata[31:8] == 24'd0));  // R10

endmodule

// File: rtl/cfg_mech_decoder.sv
module cfg_mech_decoder #(
  parameter int          PORT_W    = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic [PORT_W-1:0] io_port,
  input  logic [1:0]        io_size,
  input  logic              io_wr,
  input  logic [31:0]       io_wdata,
  output logic              io_done,
  output logic [31:0]       io_rdata,
  output logic              io_busy,
  input  logic [7:0]        tgt_bus,
  input  logic [4:0]        tgt_dev,
  input  logic [2:0]        tgt_fn,
  output logic              cs_req,
  output logic              cs_wr,
  output logic [7:0]        cs_off,
  output logic [1:0]        cs_size,
  output logic [31:0]       cs_wdata,
  input  logic              cs_rvalid,
  input  logic [31:0]       cs_rdata
);
  import cfgd_pkg::*;

  logic [31:0] addr_q;
  cfg_act_e    act;
  logic [7:0]  fwd_off;
  logic        start;
  logic        addr_wr_en;
  cfg_size_e   size_in;
  cfg_size_e   size_out;

  assign size_in    = cfg_size_e'(io_size);
  assign start      = io_req && !io_busy;
  assign addr_wr_en = start && (act == ACT_ADDR_WR);
  assign cs_size    = size_out;

  cfgd_addr_reg u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (addr_wr_en),
    .wdata  (io_wdata),
    .addr_q (addr_q)
  );

  cfgd_decode #(
    .PORT_W    (PORT_W),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_dec (
    .io_port      (io_port),
    .io_size      (size_in),
    .cfg_en       (cfg_enabled(addr_q)),
    .cfg_bus_no   (cfg_bus(addr_q)),
    .cfg_dev_no   (cfg_dev(addr_q)),
    .cfg_fn_no    (cfg_fn(addr_q)),
    .cfg_base_off (addr_q[7:0]),
    .tgt_bus      (tgt_bus),
    .tgt_dev      (tgt_dev),
    .tgt_fn       (tgt_fn),
    .io_wr        (io_wr),
    .act          (act),
    .fwd_off      (fwd_off)
  );

  cfgd_fwd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .act       (act),
    .fwd_off   (fwd_off),
    .io_size   (size_in),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .addr_q    (addr_q),
    .io_done   (io_done),
    .io_rdata  (io_rdata),
    .busy      (io_busy),
    .cs_req    (cs_req),
    .cs_wr     (cs_wr),
    .cs_off    (cs_off),
    .cs_size   (size_out),
    .cs_wdata  (cs_wdata),
    .cs_rvalid (cs_rvalid),
    .cs_rdata  (cs_rdata)
  );

  AST_FWD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> addr_q[31]);  // R3
  AST_FWD_TARGET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> (addr_q[23:16] == $past(tgt_bus) && addr_q[15:11] == $past(tgt_dev) &&
                addr_q[10:8] == $past(tgt_fn)));  // R6
  AST_DWORD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && cs_size == 2'd2) |-> (cs_off == addr_q[7:0]));  // R5
  AST_REQ_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> $past(io_req));  // R8

endmodule

// File: tb/cfg_mech_decoder_tb.sv
`timescale 1ns/1ps
module cfg_mech_decoder_tb;

  localparam int CF8 = 16'h0CF8;
  localparam int CFC = 16'h0CFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic [15:0] io_port = 16'd0;
  logic [1:0]  io_size = 2'd0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = 32'd0;
  logic        io_done;
  logic [31:0] io_rdata;
  logic        io_busy;
  logic [7:0]  tgt_bus = 8'h03;
  logic [4:0]  tgt_dev = 5'h05;
  logic [2:0]  tgt_fn = 3'h2;
  logic        cs_req;
  logic        cs_wr;
  logic [7:0]  cs_off;
  logic [1:0]  cs_size;
  logic [31:0] cs_wdata;
  logic        cs_rvalid = 1'b0;
  logic [31:0] cs_rdata = 32'd0;

  int n_checks = 0;
  int n_fails = 0;
  logic [31:0] m_addr;
  logic [7:0]  cfg_space [256];
  bit          done_flag = 0;

  always #5 clk = ~clk;

  cfg_mech_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_port(io_port), .io_size(io_size),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
    .io_busy(io_busy), .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn),
    .cs_req(cs_req), .cs_wr(cs_wr), .cs_off(cs_off), .cs_size(cs_size),
    .cs_wdata(cs_wdata), .cs_rvalid(cs_rvalid), .cs_rdata(cs_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] space_word(input logic [7:0] off);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) w[b*8 +: 8] = cfg_space[8'(off + 8'(b))];
    return w;
  endfunction

  // Reference model: one bus access, compared cycle by cycle
  task automatic access(input int port, input int size, input bit wr,
                        input logic [31:0] wd, input int lat, input string tag);
    bit          fwd = 0;
    logic [31:0] exp_rd = 32'd0;
    logic [7:0]  off = 8'd0;
    logic [31:0] resp;
    logic [31:0] msk;
    bit match;
    match = (m_addr[23:16] == tgt_bus) && (m_addr[15:11] == tgt_dev) && (m_addr[10:8] == tgt_fn);
    if (port == CF8 && size == 2) begin
      if (!wr) exp_rd = m_addr;
    end else if (m_addr[31] && match) begin
      if ((size == 0 || size == 1) && port >= CFC && port <= CFC + 3) begin
        fwd = 1; off = m_addr[7:0] + 8'(port - CFC);
      end else if (size == 2 && port == CFC) begin
        fwd = 1; off = m_addr[7:0];
      end
    end
    @(negedge clk);
    io_req = 1'b1; io_port = 16'(port); io_size = 2'(size); io_wr = wr; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    if (fwd) begin
      chk(cs_req == 1'b1, {tag, " R8 cs_req"}, {31'd0, cs_req}, 32'd1);
      chk(cs_off == off, {tag, " R4/R5 offset"}, {24'd0, cs_off}, {24'd0, off});
      chk(cs_size == 2'(size), {tag, " R4 size"}, {30'd0, cs_size}, size);
      chk(cs_wr == wr, {tag, " R8 dir"}, {31'd0, cs_wr}, {31'd0, wr});
      if (wr) begin
        chk(cs_wdata == wd, {tag, " R8 wdata"}, cs_wdata, wd);
        chk(io_done == 1'b1, {tag, " R8 write done"}, {31'd0, io_done}, 32'd1);
        for (int b = 0; b < (size == 0 ? 1 : (size == 1 ? 2 : 4)); b++)
          cfg_space[8'(off + 8'(b))] = wd[b*8 +: 8];
      end else begin
        resp = space_word(off);
        msk = (size == 0) ? 32'hFF : ((size == 1) ? 32'hFFFF : 32'hFFFF_FFFF);
        for (int k = 0; k < lat; k++) begin
          chk(io_done == 1'b0, {tag, " R9 early done"}, {31'd0, io_done}, 32'd0);
          @(negedge clk);
        end
        cs_rvalid = 1'b1; cs_rdata = resp;
        chk(io_done == 1'b0, {tag, " R9 done before resp"}, {31'd0, io_done}, 32'd0);
        @(negedge clk);
        cs_rvalid = 1'b0; cs_rdata = 32'hDEAD_BEEF;
        chk(io_done == 1'b1, {tag, " R9 read done"}, {31'd0, io_done}, 32'd1);
        chk(io_rdata == (resp & msk), {tag, " R10 read data"}, io_rdata, resp & msk);
      end
    end else begin
      chk(cs_req == 1'b0, {tag, " R7 no forward"}, {31'd0, cs_req}, 32'd0);
      chk(io_done == 1'b1, {tag, " R7 done"}, {31'd0, io_done}, 32'd1);
      if (!wr) chk(io_rdata == exp_rd, {tag, " R2/R7 read data"}, io_rdata, exp_rd);
      if (wr && port == CF8 && size == 2) m_addr = wd & 32'h80FF_FFFC;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!io_done && !cs_req, {tag, " idle"}, {30'd0, io_done, cs_req}, 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) cfg_space[i] = 8'(i) ^ 8'h5A;
    m_addr = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1 reset quiet");
    access(CF8, 2, 0, 0, 0, "R1 reset address");
    access(CFC, 2, 0, 0, 0, "R1 window disabled after reset");
    access(CF8, 2, 1, 32'hFFFF_FFFF, 0, "R2 masked write");
    access(CF8, 2, 0, 0, 0, "R2 read back");
    access(CF8, 2, 1, 32'h0003_2A10, 0, "R3 enable clear");
    access(CFC, 2, 1, 32'h1234_5678, 0, "R3 write disabled");
    access(CFD, 0, 0, 0, 0, "R3 byte read disabled");
    access(CF8, 2, 1, 32'h8003_2A13, 0, "R2 low bits cleared");
    access(CF8, 2, 0, 0, 0, "R2 aligned read back");
    access(CFC, 2, 1, 32'h1122_3344, 0, "R5 dword write");
    access(CFC, 2, 0, 0, 0, "R9 same-cycle response");
    access(CFC, 2, 0, 0, 3, "R9 delayed response");
    access(CFD, 0, 0, 0, 1, "R4 byte read lane1");
    access(CFE, 1, 0, 0, 2, "R10 word read lane2");
    access(CFF, 0, 1, 32'hFFFF_FFAB, 0, "R4 byte write lane3");
    access(CFE, 1, 1, 32'h0000_BEEF, 0, "R4 word write lane2");
    access(CFC, 2, 0, 0, 1, "R4 merged dword");
    access(CFC, 0, 0, 0, 0, "R10 byte zero-ext");
    access(CFD, 2, 0, 0, 0, "R7 dword at lane1");
    access(CFF, 2, 1, 32'h0, 0, "R7 dword write lane3");
    access(CF8, 0, 0, 0, 0, "R7 byte read addr port");
    access(CF8, 1, 1, 32'h0000_0000, 0, "R7 word write addr port");
    access(CF8, 2, 0, 0, 0, "R7 address kept");
    access(16'h0080, 0, 0, 0, 0, "R7 foreign port");
    idle(1, "R9 pre stray");
    @(negedge clk); cs_rvalid = 1'b1; cs_rdata = 32'h5555_5555;
    @(negedge clk); cs_rvalid = 1'b0;
    chk(!io_done, "R9 stray rvalid ignored", {31'd0, io_done}, 32'd0);
    idle(2, "R9 post stray");
    access(CF8, 2, 1, 32'h8003_3210, 0, "R6 other device");
    access(CFC, 2, 0, 0, 0, "R6 mismatch read zero");
    access(CFC, 2, 1, 32'hAAAA_AAAA, 0, "R6 mismatch write dropped");
    access(CF8, 2, 1, 32'h8004_2A10, 0, "R6 other bus");
    access(CFD, 0, 0, 0, 0, "R6 bus mismatch");
    access(CF8, 2, 1, 32'h8003_2B10, 0, "R6 other function");
    access(CFC, 1, 1, 32'h0000_0101, 0, "R6 fn mismatch write");
    access(CF8, 2, 1, 32'h8003_2A10, 0, "R6 back to target");
    access(CFC, 2, 0, 0, 1, "R6 space unchanged");
    idle(2, "R8 tail");
    done_flag = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  localparam int CFD = CFC + 1;
  localparam int CFE = CFC + 2;
  localparam int CFF = CFC + 3;

endmodule